// File: doc/BRIEF.md
# Radix-4 Carry-Save Fraction Divider

This block divides one unsigned fraction by another. It takes a 24-bit dividend and a 24-bit divisor, both read as fractions with the binary point above the most significant bit. It returns a quotient with one integer bit and 24 fraction bits, plus an integer remainder. The divisor must be normalized, with its top bit set. The block works sequentially. Each clock produces one signed quotient digit from {-2,-1,0,+1,+2}, which is worth two quotient bits.

The running remainder is held as a pair of sum and carry vectors and is updated by a single carry-save stage. The next digit comes from a small selection function. That function looks at three divisor bits below the leading one and a 7-bit estimate built from the top bits of the sum and carry vectors. Because the digit set is redundant, no step ever restores the remainder and no carry-propagate add runs inside the loop. Positive and negative digits are collected in two separate registers. One closing cycle then subtracts these two registers, adds back the divisor when the final remainder is negative, and adjusts the quotient to match.

The caller pulses `start` while `busy` is low and waits for the one-cycle `done` pulse. A zero divisor finishes at once and raises the error flag.

Top module: `srtDivider`

## Requirements
- R1: After reset, `quotient`, `remainder`, `done`, `busy` and `divByZero` are all zero.
- R2: For a divisor with bit 23 set and any dividend X, with divisor D, the 25-bit `quotient` equals floor(X·2^24 / D) and `remainder` equals X·2^24 − quotient·D.
- R3: Every non-error result has a remainder in the range [0, D).
- R4: For a nonzero divisor, `done` rises on the 14th rising edge after the edge that samples `start`. `busy` is high from that sampling edge until the edge that raises `done`.
- R5: `done` stays high for exactly one clock cycle.
- R6: A `start` pulse seen while `busy` is high is ignored. The running division finishes on schedule with its original operands.
- R7: A zero divisor raises `done` on the first edge after the sampling edge. It sets `divByZero`, sets all 25 quotient bits to one and sets the remainder to zero. The next division with a nonzero divisor clears `divByZero`.
- R8: `quotient`, `remainder` and `divByZero` hold their values between `done` pulses.
- R9: Before every iteration, the 7-bit estimate of four times the partial remainder lies between −45 and +43 sixteenths. This is the convergence bound of the digit selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; honoured only while idle |
| dividend | input | 24 | Dividend fraction X / 2^24 |
| divisor | input | 24 | Divisor fraction D / 2^24, top bit set, or zero |
| quotient | output | 25 | Quotient, one integer bit and 24 fraction bits |
| remainder | output | 24 | Remainder, X·2^24 − quotient·D |
| done | output | 1 | One-cycle result strobe |
| busy | output | 1 | Division in progress |
| divByZero | output | 1 | Last result came from a zero divisor |

## Verification
The convergence assertion holds only if every nonzero divisor has its top bit set. An unnormalized divisor falls outside the selection intervals, so the remainder bound may legitimately be broken. The bench therefore only ever drives divisors that are zero or have bit 23 forced high, including the pseudo-random ones. Dividends are drawn across the full 24-bit range, which covers quotients from zero up to just under two. The remainder and zero-divisor assertions assume that operands are sampled only on an idle `start`. For that reason, the one overlapping `start` the bench issues comes while `busy` is high.

// File: rtl/srtDivPkg.sv
package srtDivPkg;

  typedef struct packed {
    logic load;     // capture operands, seed remainder
    logic iterate;  // retire one radix-4 digit
    logic finish;   // convert and publish the result
  } divCtl_t;

  typedef struct packed {
    logic       neg;  // digit is negative
    logic [1:0] mag;  // magnitude 0, 1 or 2
  } qDigit_t;

endpackage

// File: rtl/srtDigitSel.sv
module srtDigitSel
  import srtDivPkg::*;
(
  input  logic [2:0]        divIdx,
  input  logic signed [6:0] est,
  output qDigit_t           digit
);

  // Threshold per divisor interval [ (8+i)/16 , (9+i)/16 ), in sixteenths of 4w.
  logic signed [6:0] tPlus2 [8];
  logic signed [6:0] tPlus1 [8];
  logic signed [6:0] tZero  [8];
  logic signed [6:0] tMin1  [8];

  generate
    for (genvar i = 0; i < 8; i++) begin : g_interval
      localparam int DLO = 8 + i;
      localparam int DHI = 9 + i;
      assign tPlus2[i] = 7'((4 * DHI + 2) / 3);
      assign tPlus1[i] = 7'((DHI + 2) / 3);
      assign tZero[i]  = 7'(-((2 * DLO) / 3));
      assign tMin1[i]  = 7'(-((5 * DLO) / 3));
    end
  endgenerate

  always_comb begin
    if (est >= tPlus2[divIdx])      digit = '{neg: 1'b0, mag: 2'd2};
    else if (est >= tPlus1[divIdx]) digit = '{neg: 1'b0, mag: 2'd1};
    else if (est >= tZero[divIdx])  digit = '{neg: 1'b0, mag: 2'd0};
    else if (est >= tMin1[divIdx])  digit = '{neg: 1'b1, mag: 2'd1};
    else                            digit = '{neg: 1'b1, mag: 2'd2};
  end

endmodule

// File: rtl/srtDivCtrl.sv
module srtDivCtrl
  import srtDivPkg::*;
#(
  parameter int N = 24
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    zeroDivisor,
  output divCtl_t ctl,
  output logic    busy,
  output logic    done
);

  localparam int ITERS = (N + 2) / 2;
  localparam int CW    = $clog2(ITERS + 1);

  typedef enum logic [1:0] {IDLE, ITER, FINAL} state_t;

  state_t        state;
  logic [CW-1:0] iterCnt;

  always_comb begin
    ctl.load    = (state == IDLE) && start;
    ctl.iterate = (state == ITER);
    ctl.finish  = (state == FINAL);
  end

  assign busy = (state != IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        IDLE: if (start) begin
          iterCnt <= '0;
          state   <= zeroDivisor ? FINAL : ITER;
        end
        ITER: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == CW'(ITERS - 1)) state <= FINAL;
        end
        FINAL: begin
          done  <= 1'b1;
          state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R5: done is a single-cycle strobe
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: done arrives with the block already idle
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/srtDivDatapath.sv
module srtDivDatapath
  import srtDivPkg::*;
#(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rstN,
  input  divCtl_t      ctl,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic         zeroDivisor,
  output logic [N:0]   quotient,
  output logic [N-1:0] remainder,
  output logic         divByZero
);

  localparam int FB   = N + 2;   // fraction bits of the partial remainder
  localparam int RW   = N + 6;   // remainder register width
  localparam int QW   = N + 3;   // digit accumulator width
  localparam int ELSB = FB - 6;  // estimate of 4w: bits of w at 1/64 ...
  localparam int EMSB = FB;      // ... up to the 4s place after shifting

  logic [N-1:0]  divReg;
  logic          zeroReg;
  logic [RW-1:0] sumR, carR;
  logic [QW-1:0] qPos, qNeg;

  logic signed [6:0] est;
  qDigit_t           digit;
  logic [RW-1:0]     dScaled, mult, addend, a4, b4, nextSum, nextCar;
  logic              subtract;
  logic signed [RW-1:0] wFin, remRaw, remFix;
  logic [QW-1:0]     qRaw;
  logic              negRem;

  assign zeroDivisor = (divisor == '0);

  // 7-bit estimate of 4w: truncated sum plus truncated carry, wrapping
  assign est = 7'(sumR[EMSB:ELSB]) + 7'(carR[EMSB:ELSB]);

  srtDigitSel u_sel (
    .divIdx (divReg[N-2:N-4]),
    .est    (est),
    .digit  (digit)
  );

  always_comb begin
    dScaled  = RW'({divReg, 2'b00});
    mult     = (digit.mag == 2'd2) ? (dScaled << 1) :
               (digit.mag == 2'd1) ? dScaled : '0;
    subtract = !digit.neg && (digit.mag != 2'd0);
    addend   = subtract ? ~mult : mult;
    a4       = sumR << 2;
    b4       = carR << 2;
    nextSum  = a4 ^ b4 ^ addend;
    nextCar  = (((a4 & b4) | (a4 & addend) | (b4 & addend)) << 1) | RW'(subtract);
  end

  always_comb begin
    wFin   = signed'(sumR + carR);
    negRem = wFin[RW-1];
    remRaw = wFin >>> 2;
    remFix = negRem ? remRaw + signed'(RW'(divReg)) : remRaw;
    qRaw   = qPos - qNeg - QW'(negRem);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg    <= '0;
      zeroReg   <= 1'b0;
      sumR      <= '0;
      carR      <= '0;
      qPos      <= '0;
      qNeg      <= '0;
      quotient  <= '0;
      remainder <= '0;
      divByZero <= 1'b0;
    end else begin
      if (ctl.load) begin
        divReg  <= divisor;
        zeroReg <= zeroDivisor;
        sumR    <= RW'(dividend);   // w0 = x/4 in units of 2^-FB
        carR    <= '0;
        qPos    <= '0;
        qNeg    <= '0;
      end
      if (ctl.iterate) begin
        sumR <= nextSum;
        carR <= nextCar;
        qPos <= {qPos[QW-3:0], digit.neg ? 2'b00 : digit.mag};
        qNeg <= {qNeg[QW-3:0], digit.neg ? digit.mag : 2'b00};
      end
      if (ctl.finish) begin
        divByZero <= zeroReg;
        quotient  <= zeroReg ? '1 : qRaw[N:0];
        remainder <= zeroReg ? '0 : remFix[N-1:0];
      end
    end
  end

  // R9: redundant remainder stays inside the selection bound
  a_r9_est_bound: assert property (@(posedge clk) disable iff (!rstN)
    ctl.iterate |-> (est >= -7'sd45) && (est <= 7'sd43));

  // R6: operands never change while digits are being retired
  a_r6_operands_held: assert property (@(posedge clk) disable iff (!rstN)
    ctl.iterate |=> $stable(divReg));

  // R2: corrected quotient and remainder fit their output widths
  a_r2_result_fits: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && !zeroReg) |-> (remFix[RW-1:N] == '0) && (qRaw[QW-1:N+1] == '0));

  // R3: published remainder is below the divisor
  a_r3_rem_below_div: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && !zeroReg) |=> (remainder < divReg) && !divByZero);

  // R7: zero divisor yields the error flag and an all-ones quotient
  a_r7_zero_result: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && zeroReg) |=> divByZero && (&quotient) && (remainder == '0));

endmodule

// File: rtl/srtDivider.sv
module srtDivider
  import srtDivPkg::*;
#(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic [N:0]   quotient,
  output logic [N-1:0] remainder,
  output logic         done,
  output logic         busy,
  output logic         divByZero
);

  divCtl_t ctl;
  logic    zeroDivisor;

  srtDivCtrl #(.N(N)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .zeroDivisor (zeroDivisor),
    .ctl         (ctl),
    .busy        (busy),
    .done        (done)
  );

  srtDivDatapath #(.N(N)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .dividend    (dividend),
    .divisor     (divisor),
    .zeroDivisor (zeroDivisor),
    .quotient    (quotient),
    .remainder   (remainder),
    .divByZero   (divByZero)
  );

endmodule

// File: tb/srtDivider_bench.sv
module srtDivider_bench;

  localparam int N = 24;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] dividend = '0;
  logic [N-1:0] divisor = '0;
  logic [N:0]   quotient;
  logic [N-1:0] remainder;
  logic         done, busy, divByZero;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  srtDivider #(.N(N)) u_srtDivider (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .remainder(remainder), .done(done), .busy(busy),
    .divByZero(divByZero)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Pulse start for one cycle; returns after the sampling edge.
  task automatic pulseStart(input logic [N-1:0] x, input logic [N-1:0] d);
    @(negedge clk);
    dividend = x; divisor = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output int cyc);
    cyc = 0;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic runDiv(input logic [N-1:0] x, input logic [N-1:0] d);
    longint num, q, r;
    int cyc;
    num = longint'(x) << N;
    q = num / longint'(d);
    r = num - q * longint'(d);
    pulseStart(x, d);
    chk("R4 busy after start", longint'(busy), 1);
    waitDone(cyc);
    chk("R4 latency", cyc, 14);
    chk("R4 busy low at done", longint'(busy), 0);
    chk("R2 quotient", longint'(quotient), q);
    chk("R2 remainder", longint'(remainder), r);
    chk("R3 remainder below divisor", longint'(remainder < d), 1);
    chk("R7 flag clear", longint'(divByZero), 0);
    @(negedge clk);
    chk("R5 done one cycle", longint'(done), 0);
  endtask

  task automatic testReset();
    chk("R1 quotient", longint'(quotient), 0);
    chk("R1 remainder", longint'(remainder), 0);
    chk("R1 done", longint'(done), 0);
    chk("R1 busy", longint'(busy), 0);
    chk("R1 divByZero", longint'(divByZero), 0);
  endtask

  task automatic testDirected();
    runDiv(24'h000000, 24'h800000);  // zero dividend
    runDiv(24'hFFFFFF, 24'h800000);  // largest quotient
    runDiv(24'hFFFFFF, 24'hFFFFFF);  // exactly one
    runDiv(24'h000001, 24'hFFFFFF);  // tiny quotient
    runDiv(24'h7FFFFF, 24'h800000);  // just under one
    runDiv(24'h555555, 24'hC00000);
    runDiv(24'hABCDEF, 24'h876543);
    runDiv(24'h800000, 24'h800001);
  endtask

  task automatic testRandom();
    logic [31:0] seed = 32'h1234_5678;
    logic [N-1:0] x, d;
    for (int i = 0; i < 60; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      x = seed[31:8];
      seed = seed * 32'd1103515245 + 32'd12345;
      d = {1'b1, seed[30:8]};
      runDiv(x, d);
    end
  endtask

  task automatic testZero();
    int cyc;
    pulseStart(24'h123456, 24'h000000);
    waitDone(cyc);
    chk("R7 zero latency", cyc, 1);
    chk("R7 flag", longint'(divByZero), 1);
    chk("R7 quotient all ones", longint'(quotient), 64'h1FFFFFF);
    chk("R7 remainder zero", longint'(remainder), 0);
    runDiv(24'h400000, 24'h900000);  // R7: flag clears on next normal result
  endtask

  task automatic testIgnore();
    int cyc;
    longint num, q;
    num = longint'(24'h3A5C7E) << N;
    q = num / longint'(24'hB1F00D);
    pulseStart(24'h3A5C7E, 24'hB1F00D);
    repeat (3) @(negedge clk);
    dividend = 24'hFFFFFF; divisor = 24'h800000; start = 1'b1;  // R6: overlap
    @(negedge clk);
    start = 1'b0;
    cyc = 4;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    chk("R6 latency unchanged", cyc, 14);
    chk("R6 original quotient", longint'(quotient), q);
    chk("R6 original remainder", longint'(remainder), num - q * longint'(24'hB1F00D));
  endtask

  task automatic testHold();
    logic [N:0] q0;
    logic [N-1:0] r0;
    q0 = quotient; r0 = remainder;
    dividend = 24'h111111; divisor = 24'h999999;
    repeat (6) @(negedge clk);
    chk("R8 quotient held", longint'(quotient), longint'(q0));
    chk("R8 remainder held", longint'(remainder), longint'(r0));
    chk("R8 no done", longint'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDirected();
    testZero();
    testIgnore();
    testHold();
    testRandom();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule